// File: doc/BRIEF.md
# Pattern-Space Bank Mapper with Half Swap

This block turns the 8 KiB pattern address space seen by the video chip into an address within a 256 KiB character ROM. The ROM is selected in 1 KiB units. Six bank registers control the mapping. Two of them select 2 KiB windows and four select 1 KiB windows.

A control register holds two mode bits. The first bit chooses which half of the pattern space holds the pair of 2 KiB windows. The second bit chooses the nametable mirroring, which the block drives out as the nametable RAM A10 line.

The CPU loads the registers through a write strobe, a 16-bit address and an 8-bit data bus. The register group starts at a base address given as a parameter. The video side supplies address bits A12..A10. From those bits and the stored bank values, the block forms ROM address bits 17..10 and the nametable A10 line with no clock delay.

Top module: `chr_bank_mapper`

## Requirements
- R1: After reset, every bank register and both mode bits are 0. Every video address then maps to ROM bank 0, and the nametable A10 output follows video A11.
- R2: Writes to base+0 and base+1 store data bits 7:1 as the two 2 KiB bank numbers, and data bit 0 is discarded. Inside a 2 KiB window, video A10 supplies ROM address bit 10.
- R3: Writes to base+2 through base+5 store all 8 data bits as the four 1 KiB bank numbers. These bank numbers appear unchanged on ROM address bits 17..10.
- R4: With the swap bit at 0, the 2 KiB windows cover $0000 (base+0) and $0800 (base+1). The 1 KiB windows cover $1000, $1400, $1800 and $1C00, from base+2 to base+5 in that order.
- R5: With the swap bit at 1, the 2 KiB windows cover $1000 (base+0) and $1800 (base+1). The 1 KiB windows cover $0000, $0400, $0800 and $0C00, from base+2 to base+5 in that order.
- R6: Register base+6 holds the mode bits. Bit 0 is mirroring: 0 makes the nametable A10 output follow video A11, and 1 makes it follow video A10. Bit 1 is the swap bit.
- R7: A write has no effect on any output when the strobe is low, or when the address is outside base..base+6. Addresses base+7 to base+15 and base-16 are among those outside the range.
- R8: A write takes effect at the clock edge that samples the strobe and not before that edge. The outputs follow the video address within the same cycle.
- R9: Data bits 7:2 of a write to base+6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU register write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ppu_a | input | 3 | Video address bits A12..A10 |
| chr_a | output | 8 | ROM address bits 17..10 |
| ciram_a10 | output | 1 | Nametable RAM A10 |

## Verification
Register writes are the only timed path. A write is driven on a falling edge, captured at the next rising edge, and due on the outputs right after that edge. The outputs depend on the video address without any register, so each video address is applied on a falling edge and the outputs are sampled 1 ns later, far from any rising edge. One test checks a write both before and after its capturing edge, to show that the value is not visible early. All eight video addresses are swept after each change to the configuration, in both swap modes and both mirroring modes.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  // two wide windows, four narrow windows, one mode register
  localparam int BIG_CNT = 2;
  localparam int SML_CNT = 4;
  localparam int CTRL_OFS = BIG_CNT + SML_CNT;
  localparam int REG_CNT = CTRL_OFS + 1;
  // positions inside the mode register
  localparam int MIRROR_BIT = 0;
  localparam int SWAP_BIT = 1;
endpackage

// File: rtl/chr_reg_file.sv
module chr_reg_file
  import chr_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h7EF0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BANK_W-1:0] wr_data,
  output logic [BIG_CNT-1:0][BANK_W-2:0] big_q,
  output logic [SML_CNT-1:0][BANK_W-1:0] sml_q,
  output logic swap_q,
  output logic vert_q
);
  logic [ADDR_W-1:0] rel;
  logic hit;

  assign rel = wr_addr - REG_BASE;
  assign hit = wr_en && (rel < ADDR_W'(REG_CNT));

  for (genvar g = 0; g < BIG_CNT; g++) begin : g_big
    always_ff @(posedge clk) begin
      if (rst) big_q[g] <= '0;
      else if (hit && rel == ADDR_W'(g)) big_q[g] <= wr_data[BANK_W-1:1];
    end
  end

  for (genvar g = 0; g < SML_CNT; g++) begin : g_sml
    always_ff @(posedge clk) begin
      if (rst) sml_q[g] <= '0;
      else if (hit && rel == ADDR_W'(BIG_CNT + g)) sml_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      swap_q <= 1'b0;
      vert_q <= 1'b0;
    end else if (hit && rel == ADDR_W'(CTRL_OFS)) begin
      swap_q <= wr_data[SWAP_BIT];
      vert_q <= wr_data[MIRROR_BIT];
    end
  end
endmodule

// File: rtl/chr_slot_sel.sv
module chr_slot_sel
  import chr_map_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic [2:0] ppu_a,
  input  logic swap,
  input  logic [BIG_CNT-1:0][BANK_W-2:0] big_q,
  input  logic [SML_CNT-1:0][BANK_W-1:0] sml_q,
  output logic [BANK_W-1:0] chr_a
);
  logic eff_hi;

  // the swap bit flips A12 before the slot lookup
  assign eff_hi = ppu_a[2] ^ swap;

  always_comb begin
    if (!eff_hi) chr_a = {big_q[ppu_a[1]], ppu_a[0]};
    else         chr_a = sml_q[ppu_a[1:0]];
  end
endmodule

// File: rtl/chr_mirror.sv
module chr_mirror (
  input  logic [1:0] ppu_a_lo,
  input  logic vert,
  output logic ciram_a10
);
  // vertical follows A10, horizontal follows A11
  assign ciram_a10 = vert ? ppu_a_lo[0] : ppu_a_lo[1];
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h7EF0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BANK_W-1:0] wr_data,
  input  logic [2:0] ppu_a,
  output logic [BANK_W-1:0] chr_a,
  output logic ciram_a10
);
  logic [BIG_CNT-1:0][BANK_W-2:0] big_q;
  logic [SML_CNT-1:0][BANK_W-1:0] sml_q;
  logic swap_q;
  logic vert_q;

  chr_reg_file #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_BASE(REG_BASE)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .big_q(big_q), .sml_q(sml_q), .swap_q(swap_q), .vert_q(vert_q)
  );

  chr_slot_sel #(.BANK_W(BANK_W)) sel_i (
    .ppu_a(ppu_a), .swap(swap_q), .big_q(big_q), .sml_q(sml_q), .chr_a(chr_a)
  );

  chr_mirror mir_i (
    .ppu_a_lo(ppu_a[1:0]), .vert(vert_q), .ciram_a10(ciram_a10)
  );
endmodule

// File: rtl/chr_bank_mapper_chk.sv
module chr_bank_mapper_chk #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h7EF0
) (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BANK_W-1:0] wr_data,
  input logic [2:0] ppu_a,
  input logic [BANK_W-1:0] chr_a,
  input logic ciram_a10,
  input logic swap_q
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (chr_a == '0 && ciram_a10 == ppu_a[1]));

  // R2
  big_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_BASE) |=>
      (!(ppu_a[2] == swap_q && !ppu_a[1]) || chr_a == {$past(wr_data[BANK_W-1:1]), ppu_a[0]}));

  // R3
  sml_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_BASE + 2) |=>
      (!(ppu_a == {~swap_q, 2'b00}) || chr_a == $past(wr_data)));

  // R6
  mirror_vert_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_BASE + 6 && wr_data[0]) |=> ciram_a10 == ppu_a[0]);

  // R6
  mirror_horz_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_BASE + 6 && !wr_data[0]) |=> ciram_a10 == ppu_a[1]);

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(ppu_a)) |-> ($stable(chr_a) && $stable(ciram_a10)));
endmodule

bind chr_bank_mapper chr_bank_mapper_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_BASE(REG_BASE)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ppu_a(ppu_a), .chr_a(chr_a), .ciram_a10(ciram_a10), .swap_q(swap_q)
);

// File: tb/chr_bank_mapper_tb_top.sv
module chr_bank_mapper_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic wr_en;
  logic [15:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] ppu_a;
  logic [7:0] chr_a;
  logic ciram_a10;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_big [2];
  logic [7:0] m_sml [4];
  logic m_swap, m_vert;

  always #2 clk = ~clk;

  chr_bank_mapper dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ppu_a(ppu_a), .chr_a(chr_a), .ciram_a10(ciram_a10)
  );

  function automatic logic [7:0] exp_chr(input logic [2:0] p);
    if ((p[2] ^ m_swap) == 1'b0) return {m_big[p[1]][7:1], p[0]};
    return m_sml[p[1:0]];
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] rel;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    rel = a - 16'h7EF0;
    if (rel < 2) m_big[rel[0]] = d;
    else if (rel < 6) m_sml[rel[1:0] - 2'd2] = d;
    else if (rel == 6) begin m_vert = d[0]; m_swap = d[1]; end
  endtask

  task automatic sweep(input string ctag, input string mtag);
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      ppu_a = 3'(p);
      #1;
      chk(ctag, chr_a, exp_chr(3'(p)));
      chk(mtag, {7'd0, ciram_a10}, {7'd0, m_vert ? ppu_a[0] : ppu_a[1]});
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ppu_a = '0;
    for (int i = 0; i < 2; i++) m_big[i] = '0;
    for (int i = 0; i < 4; i++) m_sml[i] = '0;
    m_swap = 1'b0; m_vert = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, all zero and A11 mirroring
    sweep("R1", "R1");

    // R2: bit 0 dropped, A10 fills the low bank bit
    wr(16'h7EF0, 8'h55);
    ppu_a = 3'd0; #1; chk("R2", chr_a, 8'h54);
    ppu_a = 3'd1; #1; chk("R2", chr_a, 8'h55);
    wr(16'h7EF1, 8'hAB);
    ppu_a = 3'd2; #1; chk("R2", chr_a, 8'hAA);
    ppu_a = 3'd3; #1; chk("R2", chr_a, 8'hAB);

    // R3: full 8-bit narrow banks
    wr(16'h7EF2, 8'hFF);
    ppu_a = 3'd4; #1; chk("R3", chr_a, 8'hFF);
    wr(16'h7EF5, 8'h81);
    ppu_a = 3'd7; #1; chk("R3", chr_a, 8'h81);

    // R4 / R5 / R6: sweeps over bank patterns and all mode pairs
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 6; k++) wr(16'h7EF0 + 16'(k), 8'((r * 73 + k * 29 + 17) & 255));
      wr(16'h7EF6, 8'(r & 3));
      if (m_swap) sweep("R5", "R6");
      else sweep("R4", "R6");
    end

    // R7: writes outside the range or without strobe
    wr(16'h7EF7, 8'h3C);
    wr(16'h7EFF, 8'hC3);
    wr(16'h6EF0, 8'h11);
    wr(16'h7EE6, 8'h03);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 16'h7EF2; wr_data = 8'h5A;
    @(negedge clk);
    wr_addr = 16'h7EF6; wr_data = 8'h03;
    @(negedge clk);
    sweep("R7", "R7");

    // R9: upper mode bits ignored
    wr(16'h7EF6, 8'hFC);
    sweep("R9", "R9");
    wr(16'h7EF6, 8'hFF);
    sweep("R9", "R9");

    // R8: value invisible before its capturing edge, visible after
    wr(16'h7EF6, 8'h00);
    @(negedge clk);
    ppu_a = 3'd4;
    wr_en = 1'b1; wr_addr = 16'h7EF2; wr_data = 8'h3E;
    #1;
    chk("R8", chr_a, m_sml[0]);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    m_sml[0] = 8'h3E;
    chk("R8", chr_a, 8'h3E);
    ppu_a = 3'd5; #1;
    chk("R8", chr_a, m_sml[1]);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule